// File: doc/BRIEF.md
# Access-Count Dead Line Predictor

This block guesses when a cache line will not be used again before it is evicted. While a line is resident, the block counts only the accesses that promote the line into the most-recently-used position. Repeated hits to a line that is already MRU are therefore not counted. When the line is evicted, its final count is written into a small history table. The table is indexed by a folded hash of the line's tag. When the same tag, or any tag with the same hash, is filled again, the stored count becomes the prediction. Once the live count reaches that prediction, the line is flagged dead.

A prediction is trusted only after two residences in a row have ended with the same count. A learned count of zero never produces a dead flag. The flags are presented as one bit per line, so that replacement, bypass and power-gating logic can consume them. A query port returns the lowest-numbered dead way of a chosen set.

The block does not hold the cache arrays. It also does not decide what to do with a dead line.

Top module: `dbp_predictor`

## Requirements
- R1: After reset every dead flag is 0, the query valid bit is 0, and every history entry holds count 0 with no confidence.
- R2: The history index of a tag is the XOR fold of the tag: tag bit b goes into index bit (b mod 8). Two tags with the same fold share one history entry.
- R3: A promoting access (`acc_promote`=1) to a valid line adds one to its live count, which saturates at 15. An access with `acc_promote`=0 leaves the count unchanged.
- R4: A line is flagged dead while all three of these hold: it is valid, its latched prediction is confident, and its live count is at or above its nonzero predicted count.
- R5: A line whose latched prediction is 0 is never flagged dead.
- R6: Evicting a valid line writes its live count into the history entry of the tag it was filled with. The entry becomes confident when the written count equals the count already stored there.
- R7: A residence that ends with a count different from the stored one clears the entry's confidence. A line filled from a non-confident entry is not flagged dead.
- R8: An eviction makes the line invalid and clears its dead flag. Accesses and evictions aimed at an invalid line change nothing.
- R9: The query returns the lowest-numbered way of `qry_set` whose dead flag is set, with `qry_valid`=1. If no way in the set is dead, it returns way 0 with `qry_valid`=0.
- R10: One event is applied per cycle, in this priority: evict, then fill, then promoting access. A fill clears the live count and the dead flag, and latches the prediction and confidence from the history entry.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| fill_valid | input | 1 | A line is being filled |
| fill_set | input | 4 | Set of the filled line |
| fill_way | input | 2 | Way of the filled line |
| fill_tag | input | 20 | Tag of the filled line |
| acc_valid | input | 1 | A line is being accessed |
| acc_set | input | 4 | Set of the accessed line |
| acc_way | input | 2 | Way of the accessed line |
| acc_promote | input | 1 | The access moves the line into the MRU position |
| evict_valid | input | 1 | A line is being evicted |
| evict_set | input | 4 | Set of the evicted line |
| evict_way | input | 2 | Way of the evicted line |
| dead_flags | output | 64 | Dead flag per line, bit index {set, way} |
| qry_set | input | 4 | Set to search for a dead way |
| qry_way | output | 2 | Lowest dead way of that set |
| qry_valid | output | 1 | The set holds at least one dead way |

## Verification
Directed residences are used first. A tag is trained with the same count twice, which separates confident prediction from a single noisy residence. Non-promoting hits are mixed in, which separates promotion counting from counting every hit. Tags that differ but fold to the same index show that the hash positions are right. Same-cycle fill-with-evict and fill-with-access pairs expose the event priority. Long residences push the live count to its saturation point. A long random run then mixes all events over a few colliding tags, and every dead flag and query result is compared with a behavioural model on each cycle.

// File: rtl/dbp_pkg.sv
package dbp_pkg;
   typedef enum logic [1:0] {
      EV_NONE   = 2'd0,
      EV_FILL   = 2'd1,
      EV_PROMO  = 2'd2,
      EV_EVICT  = 2'd3
   } dbp_event_e;
endpackage

// File: rtl/dbp_hist_table.sv
module dbp_hist_table #(
   parameter int DEPTH   = 256,
   parameter int CNT_W   = 4,
   parameter bit CONF_EN = 1'b1,
   localparam int IDX_W  = $clog2(DEPTH)
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic [IDX_W-1:0] rd_idx,
   output logic [CNT_W-1:0] rd_cnt,
   output logic             rd_conf,
   input  logic             wr_en,
   input  logic [IDX_W-1:0] wr_idx,
   input  logic [CNT_W-1:0] wr_cnt
);
   logic [CNT_W-1:0] cnt_q  [DEPTH];
   logic             conf_q [DEPTH];
   logic             conf_nxt;

   generate
      if (CONF_EN) begin : g_conf_repeat
         assign conf_nxt = (cnt_q[wr_idx] == wr_cnt);
      end else begin : g_conf_always
         assign conf_nxt = 1'b1;
      end
   endgenerate

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         for (int i = 0; i < DEPTH; i++) begin
            cnt_q[i]  <= '0;
            conf_q[i] <= 1'b0;
         end
      end else if (wr_en) begin
         cnt_q[wr_idx]  <= wr_cnt;
         conf_q[wr_idx] <= conf_nxt;
      end
   end

   assign rd_cnt  = cnt_q[rd_idx];
   assign rd_conf = conf_q[rd_idx];

   generate
      if (CONF_EN) begin : g_conf_chk
         AST_CONF_BREAK: assert property (@(posedge clk) disable iff (!rst_n)
            (wr_en && (cnt_q[wr_idx] != wr_cnt)) |=> !conf_q[$past(wr_idx)]); // R7
      end
   endgenerate
endmodule

// File: rtl/dbp_line_state.sv
module dbp_line_state
   import dbp_pkg::*;
#(
   parameter int LINES  = 64,
   parameter int IDX_W  = 8,
   parameter int CNT_W  = 4,
   localparam int LINE_W = $clog2(LINES)
) (
   input  logic              clk,
   input  logic              rst_n,
   input  dbp_event_e        ev,
   input  logic [LINE_W-1:0] ev_line,
   input  logic [IDX_W-1:0]  fill_idx,
   input  logic [CNT_W-1:0]  fill_pred,
   input  logic              fill_conf,
   output logic [LINES-1:0]  dead,
   output logic              sel_valid,
   output logic [IDX_W-1:0]  sel_idx,
   output logic [CNT_W-1:0]  sel_live
);
   logic [LINES-1:0]       valid_flat;
   logic [LINES*IDX_W-1:0] idx_flat;
   logic [LINES*CNT_W-1:0] live_flat;

   for (genvar i = 0; i < LINES; i++) begin : g_line
      logic             valid_q;
      logic [IDX_W-1:0] idx_q;
      logic [CNT_W-1:0] live_q;
      logic [CNT_W-1:0] pred_q;
      logic             conf_q;
      logic             hit;

      assign hit = (ev_line == LINE_W'(i));

      always_ff @(posedge clk) begin
         if (!rst_n) begin
            valid_q <= 1'b0;
            idx_q   <= '0;
            live_q  <= '0;
            pred_q  <= '0;
            conf_q  <= 1'b0;
         end else if (hit) begin
            unique case (ev)
               EV_EVICT: valid_q <= 1'b0;
               EV_FILL: begin
                  valid_q <= 1'b1;
                  idx_q   <= fill_idx;
                  live_q  <= '0;
                  pred_q  <= fill_pred;
                  conf_q  <= fill_conf;
               end
               EV_PROMO: begin
                  if (valid_q && (live_q != '1)) live_q <= live_q + 1'b1;
               end
               default: ;
            endcase
         end
      end

      assign dead[i] = valid_q && conf_q && (pred_q != '0) && (live_q >= pred_q);
      assign valid_flat[i] = valid_q;
      assign idx_flat[i*IDX_W +: IDX_W]  = idx_q;
      assign live_flat[i*CNT_W +: CNT_W] = live_q;

      AST_LIVE_SATURATES: assert property (@(posedge clk) disable iff (!rst_n)
         (hit && ev == EV_PROMO && valid_q && live_q == '1) |=> (live_q == '1)); // R3
   end

   assign sel_valid = valid_flat[ev_line];
   assign sel_idx   = idx_flat[ev_line*IDX_W +: IDX_W];
   assign sel_live  = live_flat[ev_line*CNT_W +: CNT_W];
endmodule

// File: rtl/dbp_dead_finder.sv
module dbp_dead_finder #(
   parameter int WAYS  = 4,
   localparam int WAY_W = (WAYS > 1) ? $clog2(WAYS) : 1
) (
   input  logic [WAYS-1:0]  set_dead,
   output logic [WAY_W-1:0] way,
   output logic             found
);
   always_comb begin
      way   = '0;
      found = 1'b0;
      for (int i = WAYS - 1; i >= 0; i--) begin
         if (set_dead[i]) begin
            way   = WAY_W'(i);
            found = 1'b1;
         end
      end
   end
endmodule

// File: rtl/dbp_predictor.sv
module dbp_predictor
   import dbp_pkg::*;
#(
   parameter int NUM_SETS   = 16,
   parameter int NUM_WAYS   = 4,
   parameter int TAG_W      = 20,
   parameter int CNT_W      = 4,
   parameter int HIST_DEPTH = 256,
   parameter bit CONF_EN    = 1'b1,
   localparam int SET_W  = $clog2(NUM_SETS),
   localparam int WAY_W  = $clog2(NUM_WAYS),
   localparam int LINES  = NUM_SETS * NUM_WAYS,
   localparam int LINE_W = SET_W + WAY_W,
   localparam int IDX_W  = $clog2(HIST_DEPTH)
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             fill_valid,
   input  logic [SET_W-1:0] fill_set,
   input  logic [WAY_W-1:0] fill_way,
   input  logic [TAG_W-1:0] fill_tag,
   input  logic             acc_valid,
   input  logic [SET_W-1:0] acc_set,
   input  logic [WAY_W-1:0] acc_way,
   input  logic             acc_promote,
   input  logic             evict_valid,
   input  logic [SET_W-1:0] evict_set,
   input  logic [WAY_W-1:0] evict_way,
   output logic [LINES-1:0] dead_flags,
   input  logic [SET_W-1:0] qry_set,
   output logic [WAY_W-1:0] qry_way,
   output logic             qry_valid
);
   if (NUM_SETS < 2 || (NUM_SETS & (NUM_SETS - 1)) != 0) begin : g_bad_sets
      $error("NUM_SETS must be a power of two of at least 2");
   end
   if (NUM_WAYS < 2 || (NUM_WAYS & (NUM_WAYS - 1)) != 0) begin : g_bad_ways
      $error("NUM_WAYS must be a power of two of at least 2");
   end
   if (HIST_DEPTH < 2 || (HIST_DEPTH & (HIST_DEPTH - 1)) != 0) begin : g_bad_depth
      $error("HIST_DEPTH must be a power of two of at least 2");
   end
   if (TAG_W < IDX_W || CNT_W < 1) begin : g_bad_widths
      $error("TAG_W must cover the history index and CNT_W must be positive");
   end

   dbp_event_e        ev;
   logic [LINE_W-1:0] ev_line;
   logic [IDX_W-1:0]  tag_hash;
   logic [CNT_W-1:0]  hist_cnt;
   logic              hist_conf;
   logic              sel_valid;
   logic [IDX_W-1:0]  sel_idx;
   logic [CNT_W-1:0]  sel_live;
   logic              hist_wr;
   logic [NUM_WAYS-1:0] set_dead;

   always_comb begin
      ev      = EV_NONE;
      ev_line = {acc_set, acc_way};
      if (evict_valid) begin
         ev      = EV_EVICT;
         ev_line = {evict_set, evict_way};
      end else if (fill_valid) begin
         ev      = EV_FILL;
         ev_line = {fill_set, fill_way};
      end else if (acc_valid && acc_promote) begin
         ev      = EV_PROMO;
      end
   end

   always_comb begin
      tag_hash = '0;
      for (int b = 0; b < TAG_W; b++) tag_hash[b % IDX_W] ^= fill_tag[b];
   end

   assign hist_wr = (ev == EV_EVICT) && sel_valid;

   dbp_hist_table #(
      .DEPTH   (HIST_DEPTH),
      .CNT_W   (CNT_W),
      .CONF_EN (CONF_EN)
   ) u_hist (
      .clk     (clk),
      .rst_n   (rst_n),
      .rd_idx  (tag_hash),
      .rd_cnt  (hist_cnt),
      .rd_conf (hist_conf),
      .wr_en   (hist_wr),
      .wr_idx  (sel_idx),
      .wr_cnt  (sel_live)
   );

   dbp_line_state #(
      .LINES (LINES),
      .IDX_W (IDX_W),
      .CNT_W (CNT_W)
   ) u_lines (
      .clk       (clk),
      .rst_n     (rst_n),
      .ev        (ev),
      .ev_line   (ev_line),
      .fill_idx  (tag_hash),
      .fill_pred (hist_cnt),
      .fill_conf (hist_conf),
      .dead      (dead_flags),
      .sel_valid (sel_valid),
      .sel_idx   (sel_idx),
      .sel_live  (sel_live)
   );

   assign set_dead = dead_flags[qry_set*NUM_WAYS +: NUM_WAYS];

   dbp_dead_finder #(
      .WAYS (NUM_WAYS)
   ) u_find (
      .set_dead (set_dead),
      .way      (qry_way),
      .found    (qry_valid)
   );

   AST_FILL_CLEARS_DEAD: assert property (@(posedge clk) disable iff (!rst_n)
      (ev == EV_FILL) |=> !dead_flags[$past(ev_line)]); // R10
   AST_EVICT_CLEARS_DEAD: assert property (@(posedge clk) disable iff (!rst_n)
      (ev == EV_EVICT) |=> !dead_flags[$past(ev_line)]); // R8
   AST_IDLE_HOLDS: assert property (@(posedge clk) disable iff (!rst_n)
      (ev == EV_NONE) |=> $stable(dead_flags)); // R3
   AST_QRY_POINTS_DEAD: assert property (@(posedge clk) disable iff (!rst_n)
      qry_valid |-> dead_flags[{qry_set, qry_way}]); // R9
   AST_QRY_LOWEST: assert property (@(posedge clk) disable iff (!rst_n)
      (qry_valid && qry_way != '0) |-> !dead_flags[{qry_set, qry_way - 1'b1}]); // R9
   AST_QRY_EMPTY: assert property (@(posedge clk) disable iff (!rst_n)
      !qry_valid |-> (set_dead == '0)); // R9
endmodule

// File: tb/tb_dbp_predictor.sv
module tb_dbp_predictor;
   localparam int CLK_PERIOD = 10;
   localparam int SETS = 16, WAYS = 4, LINES = 64, DEPTH = 256, TAGW = 20, CMAX = 15;

   logic clk = 1'b0, rst_n = 1'b0;
   logic fill_valid = 0, acc_valid = 0, acc_promote = 0, evict_valid = 0;
   logic [3:0] fill_set = 0, acc_set = 0, evict_set = 0, qry_set = 0;
   logic [1:0] fill_way = 0, acc_way = 0, evict_way = 0, qry_way;
   logic [19:0] fill_tag = 0;
   logic [63:0] dead_flags;
   logic qry_valid;

   int total = 0, bad = 0;
   int mv[LINES], mi[LINES], ml[LINES], mp[LINES], mc[LINES];
   int hc[DEPTH], hcf[DEPTH];

   always #(CLK_PERIOD/2) clk = ~clk;

   dbp_predictor dut (
      .clk(clk), .rst_n(rst_n),
      .fill_valid(fill_valid), .fill_set(fill_set), .fill_way(fill_way), .fill_tag(fill_tag),
      .acc_valid(acc_valid), .acc_set(acc_set), .acc_way(acc_way), .acc_promote(acc_promote),
      .evict_valid(evict_valid), .evict_set(evict_set), .evict_way(evict_way),
      .dead_flags(dead_flags), .qry_set(qry_set), .qry_way(qry_way), .qry_valid(qry_valid)
   );

   function automatic int fold(input int tag);
      int r = 0;
      for (int b = 0; b < TAGW; b++) r ^= ((tag >> b) & 1) << (b % 8);
      return r;
   endfunction

   function automatic bit mdead(input int l);
      return mv[l] != 0 && mc[l] != 0 && mp[l] != 0 && ml[l] >= mp[l];
   endfunction

   task automatic report(input bit ok, input string req, input int act, input int exp);
      total++;
      if (!ok) begin
         bad++;
         $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
      end
   endtask

   task automatic compare();
      logic [63:0] e;
      int qw = 0;
      bit qv = 0;
      for (int l = 0; l < LINES; l++) e[l] = mdead(l);
      total++;
      if (dead_flags !== e) begin
         bad++;
         $display("FAIL R4 dead flags actual=%h expected=%h", dead_flags, e);
      end
      for (int w = WAYS - 1; w >= 0; w--) if (e[qry_set*WAYS + w]) begin qw = w; qv = 1; end
      report(qry_valid === qv && (!qv || qry_way == qw), "R9 query", {qry_valid, qry_way}, {qv, qw[1:0]});
   endtask

   task automatic step(input bit f, input bit a, input bit e, input int s, input int w,
                       input int tag, input bit pr);
      int l = s * WAYS + w;
      @(negedge clk);
      compare();
      fill_valid = f; acc_valid = a; evict_valid = e; acc_promote = pr;
      fill_set = s[3:0]; acc_set = s[3:0]; evict_set = s[3:0];
      fill_way = w[1:0]; acc_way = w[1:0]; evict_way = w[1:0]; fill_tag = tag[19:0];
      if (e) begin
         if (mv[l] != 0) begin
            hcf[mi[l]] = (hc[mi[l]] == ml[l]);
            hc[mi[l]]  = ml[l];
            mv[l] = 0;
         end
      end else if (f) begin
         mv[l] = 1; mi[l] = fold(tag); ml[l] = 0;
         mp[l] = hc[mi[l]]; mc[l] = hcf[mi[l]];
      end else if (a && pr) begin
         if (mv[l] != 0 && ml[l] < CMAX) ml[l]++;
      end
      @(posedge clk);
      #1;
      fill_valid = 0; acc_valid = 0; evict_valid = 0; acc_promote = 0;
   endtask

   task automatic fill(input int s, input int w, input int t); step(1, 0, 0, s, w, t, 0); endtask
   task automatic evict(input int s, input int w); step(0, 0, 1, s, w, 0, 0); endtask
   task automatic acc(input int s, input int w, input bit pr, input int n);
      for (int i = 0; i < n; i++) step(0, 1, 0, s, w, 0, pr);
   endtask
   task automatic train(input int s, input int w, input int t, input int n);
      fill(s, w, t); acc(s, w, 1, n); evict(s, w);
   endtask

   task automatic expect_dead(input int s, input int w, input bit v, input string req);
      @(negedge clk);
      report(dead_flags[s*WAYS + w] === v, req, dead_flags[s*WAYS + w], v);
   endtask

   task automatic expect_qry(input int s, input int w, input bit v, input string req);
      qry_set = s[3:0];
      @(negedge clk);
      report(qry_valid === v && qry_way == w[1:0], req, {qry_valid, qry_way}, {v, w[1:0]});
   endtask

   localparam int TA = 20'h00012;
   localparam int TB = TA ^ 20'h00101;  // same fold as TA
   localparam int TC = 20'h0A500;
   localparam int TD = 20'h30007;

   initial begin
      repeat (200000) @(posedge clk);
      bad++;
      $display("FAIL R1 watchdog expired");
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
   end

   initial begin
      for (int l = 0; l < LINES; l++) begin mv[l] = 0; mi[l] = 0; ml[l] = 0; mp[l] = 0; mc[l] = 0; end
      for (int i = 0; i < DEPTH; i++) begin hc[i] = 0; hcf[i] = 0; end
      repeat (3) @(posedge clk);
      #1 rst_n = 1'b1;
      @(negedge clk);
      report(dead_flags === '0, "R1 reset dead flags", dead_flags, 0);
      report(qry_valid === 1'b0, "R1 reset query", qry_valid, 0);

      // first residence learns 3, second residence is not yet confident
      train(1, 2, TA, 3);
      fill(1, 2, TA); acc(1, 2, 1, 3);
      expect_dead(1, 2, 0, "R7 unconfident after one residence");
      evict(1, 2);

      // confident now: count only promotions
      fill(1, 2, TA); acc(1, 2, 1, 2);
      expect_dead(1, 2, 0, "R4 below prediction");
      acc(1, 2, 0, 5);
      expect_dead(1, 2, 0, "R3 non-promoting hits ignored");
      acc(1, 2, 1, 1);
      expect_dead(1, 2, 1, "R4 reached prediction");
      expect_qry(1, 2, 1, "R9 single dead way");
      fill(1, 0, TA); acc(1, 0, 1, 3);
      expect_qry(1, 0, 1, "R9 lowest dead way");
      evict(1, 0);
      expect_qry(1, 2, 1, "R8 evicted way drops out of query");
      expect_qry(2, 0, 0, "R9 empty set");

      // eviction of an invalid line is ignored; folded alias shares entry
      evict(1, 2);
      evict(1, 2);
      fill(1, 2, TB); acc(1, 2, 1, 3);
      expect_dead(1, 2, 1, "R2 alias tag shares history, R8 stale evict ignored");

      // change of count breaks confidence
      evict(1, 2);
      train(1, 2, TA, 2);
      fill(1, 2, TA); acc(1, 2, 1, 2);
      expect_dead(1, 2, 0, "R7 confidence cleared by new count");
      evict(1, 2);
      fill(1, 2, TA); acc(1, 2, 1, 2);
      expect_dead(1, 2, 1, "R6 repeated count restores confidence");

      // zero learned count
      train(3, 1, TC, 0); train(3, 1, TC, 0);
      fill(3, 1, TC);
      expect_dead(3, 1, 0, "R5 zero prediction never dead");
      evict(3, 1);

      // priority
      step(1, 0, 1, 1, 2, TA, 0);
      expect_dead(1, 2, 0, "R10 evict beats fill");
      acc(1, 2, 1, 4);
      expect_dead(1, 2, 0, "R8 access to invalid line ignored");
      step(1, 1, 0, 1, 2, TA, 1);
      acc(1, 2, 1, 1);
      expect_dead(1, 2, 0, "R10 fill beats access");
      acc(1, 2, 1, 1);
      expect_dead(1, 2, 1, "R10 count after fill");

      // saturation
      train(5, 3, TD, 20); train(5, 3, TD, 20);
      fill(5, 3, TD); acc(5, 3, 1, 14);
      expect_dead(5, 3, 0, "R3 saturated prediction not yet reached");
      acc(5, 3, 1, 1);
      expect_dead(5, 3, 1, "R3 saturated count reached");

      // random mix, compared on every cycle
      for (int i = 0; i < 4000; i++) begin
         int s, w, t, k;
         s = $urandom_range(0, 3);
         w = $urandom_range(0, 3);
         k = $urandom_range(0, 9);
         case ($urandom_range(0, 3))
            0: t = TA; 1: t = TB; 2: t = TC; default: t = TD;
         endcase
         qry_set = 4'($urandom_range(0, 3));
         if (k == 0) step(1, 0, 1, s, w, t, 1);
         else if (k == 1) step(1, 0, 0, s, w, t, 0);
         else if (k == 2) step(0, 0, 1, s, w, 0, 0);
         else step(0, 1, 0, s, w, 0, k > 3);
      end
      @(negedge clk);
      compare();

      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
   end
endmodule